// File: doc/BRIEF.md
# Enumeration Search Bit Responder

This block is the device half of a bit-by-bit identification search held on a shared open-drain line, where every attached device pulls low to send a 0 and releases to send a 1. A master finds every device on the line by walking a binary tree. At each tree level it takes two read slots and then one write slot. Each device holds a fixed identity word, sends its identity bits starting from the least significant, and drops out of the pass as soon as the master writes a bit that differs from its own. A device that keeps up to the last bit has been found. From then on it reports a status input on every further read slot.

The line side is reduced to a slot interface. A one-cycle read strobe takes the value on `line_o`, where 0 means pull low and 1 means release. A one-cycle write strobe carries the master's bit. A one-cycle start pulse opens a new pass. The block has no analog timing, no reset or presence pulse, and no command decoding.

The sequencer has six states. IDLE is the state after reset. SEND_TRUE drives the identity bit. SEND_COMP drives its complement. AWAIT_WRITE releases the line and waits for the master's bit. STREAM reports the status input. DROPPED releases the line until the next start. The transitions are as follows:
- start moves any state to SEND_TRUE at bit 0.
- A read in SEND_TRUE goes to SEND_COMP.
- A read in SEND_COMP goes to AWAIT_WRITE.
- A matching write in AWAIT_WRITE goes to SEND_TRUE at the next bit, or to STREAM after the last bit.
- A mismatching write, an out-of-order slot, or two slots at once goes to DROPPED.
- A write in STREAM goes to DROPPED.

Top module: `srch_responder`

## Requirements
- R1: After reset the block is in IDLE: `line_o` is 1 (released), `selected_o` is 0 and `done_o` is 0.
- R2: A start pulse selects the device and sets the bit index to 0. The identity is sent least significant bit first, so the first read after start returns identity bit 0.
- R3: At each bit position, the first read slot returns the identity bit and the second read slot returns its complement.
- R4: A write slot whose bit equals the current identity bit keeps the device selected and moves it to the next bit position.
- R5: A write slot whose bit differs from the current identity bit deselects the device (`selected_o` = 0). The device stays deselected, whatever slots follow, until the next start pulse.
- R6: While the device is not selected, `line_o` is 1 at every read slot, so the device has no effect on the wired-AND value.
- R7: A matching write on the last identity bit raises `done_o`. After that, every read slot returns the current value of `pio_i`.
- R8: A write slot that arrives where a read slot is expected (in SEND_TRUE or SEND_COMP) deselects the device.
- R9: A read slot that arrives where a write slot is expected (in AWAIT_WRITE) deselects the device.
- R10: A start pulse in the middle of a pass abandons that pass and restarts at identity bit 0 with the device selected.
- R11: A write slot in STREAM deselects the device and clears `done_o`.
- R12: A read strobe and a write strobe in the same cycle count as an out-of-order slot and deselect the device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle pulse that opens a new search pass |
| rd_slot_i | input | 1 | One-cycle read-slot strobe; the master takes `line_o` in this cycle |
| wr_slot_i | input | 1 | One-cycle write-slot strobe |
| wr_bit_i | input | 1 | Bit sent by the master in the write slot |
| pio_i | input | 1 | Status input reported once the identity has been matched |
| line_o | output | 1 | Value to drive at a read slot: 0 pulls low, 1 releases |
| selected_o | output | 1 | High while the device takes part in the pass |
| done_o | output | 1 | High once every identity bit has been matched |

## Verification
The bench builds the block with an identity width of 8 and the identity value 8'b1011_0010. With this short identity, a complete pass fits in a few dozen slots, so the change from the last matched bit into status streaming is reached in every run. The value mixes ones and zeros, so both the true-bit and complement-bit reads are seen driving each level. A mismatch placed at bit 3 shows the device dropping out partway through a pass, and later passes show how it recovers after a start pulse.

// File: rtl/srch_pkg.sv
package srch_pkg;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_SEND_TRUE = 3'd1,
        S_SEND_COMP = 3'd2,
        S_AWAIT_WR  = 3'd3,
        S_STREAM    = 3'd4,
        S_DROPPED   = 3'd5
    } srch_state_e;

    function automatic logic is_active(input srch_state_e st);
        return (st == S_SEND_TRUE) || (st == S_SEND_COMP) ||
               (st == S_AWAIT_WR)  || (st == S_STREAM);
    endfunction

endpackage

// File: rtl/srch_bit_index.sv
module srch_bit_index #(
    parameter int ID_WIDTH = 64,
    localparam int IDX_W = (ID_WIDTH > 1) ? $clog2(ID_WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             adv_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             last_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_WIDTH - 1);

    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (clr_i) begin
            idx_q <= '0;
        end else if (adv_i && (idx_q != LAST_IDX)) begin
            idx_q <= idx_q + IDX_W'(1);
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (idx_q == LAST_IDX);

    // R4
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && !last_o) |=> (idx_o == $past(idx_o) + IDX_W'(1)));

    // R2
    index_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (idx_o == '0));

endmodule

// File: rtl/srch_id_select.sv
module srch_id_select #(
    parameter int                  ID_WIDTH = 64,
    parameter logic [ID_WIDTH-1:0] ID_VALUE = '0,
    localparam int IDX_W = (ID_WIDTH > 1) ? $clog2(ID_WIDTH) : 1
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic             bit_o
);

    logic [ID_WIDTH-1:0] sel_vec;

    for (genvar g = 0; g < ID_WIDTH; g++) begin : g_pick
        assign sel_vec[g] = (idx_i == IDX_W'(g)) & ID_VALUE[g];
    end

    assign bit_o = |sel_vec;

endmodule

// File: rtl/srch_seq_fsm.sv
module srch_seq_fsm
    import srch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        rd_i,
    input  logic        wr_i,
    input  logic        match_i,
    input  logic        last_i,
    output srch_state_e state_o,
    output logic        idx_clr_o,
    output logic        idx_adv_o
);

    srch_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        idx_clr_o = 1'b0;
        idx_adv_o = 1'b0;
        if (start_i) begin
            state_d   = S_SEND_TRUE;
            idx_clr_o = 1'b1;
        end else begin
            unique case (state_q)
                S_IDLE, S_DROPPED: begin
                    state_d = state_q;
                end
                S_SEND_TRUE: begin
                    if (wr_i)      state_d = S_DROPPED;
                    else if (rd_i) state_d = S_SEND_COMP;
                end
                S_SEND_COMP: begin
                    if (wr_i)      state_d = S_DROPPED;
                    else if (rd_i) state_d = S_AWAIT_WR;
                end
                S_AWAIT_WR: begin
                    if (rd_i) begin
                        state_d = S_DROPPED;
                    end else if (wr_i) begin
                        if (!match_i) begin
                            state_d = S_DROPPED;
                        end else if (last_i) begin
                            state_d = S_STREAM;
                        end else begin
                            state_d   = S_SEND_TRUE;
                            idx_adv_o = 1'b1;
                        end
                    end
                end
                S_STREAM: begin
                    if (wr_i) state_d = S_DROPPED;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    assign state_o = state_q;

    // R9
    late_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_AWAIT_WR && rd_i && !start_i) |=> (state_q == S_DROPPED));

    // R8
    early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_SEND_TRUE || state_q == S_SEND_COMP) && wr_i && !start_i)
        |=> (state_q == S_DROPPED));

    // R10
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (state_q == S_SEND_TRUE));

    // R11
    stream_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_STREAM && wr_i && !start_i) |=> (state_q == S_DROPPED));

endmodule

// File: rtl/srch_responder.sv
module srch_responder
    import srch_pkg::*;
#(
    parameter int                  ID_WIDTH = 64,
    parameter logic [ID_WIDTH-1:0] ID_VALUE = 64'h5A00_0000_1234_ABCD
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic rd_slot_i,
    input  logic wr_slot_i,
    input  logic wr_bit_i,
    input  logic pio_i,
    output logic line_o,
    output logic selected_o,
    output logic done_o
);

    localparam int IDX_W = (ID_WIDTH > 1) ? $clog2(ID_WIDTH) : 1;

    srch_state_e      state;
    logic [IDX_W-1:0] idx;
    logic             last_bit;
    logic             cur_bit;
    logic             idx_clr;
    logic             idx_adv;

    srch_bit_index #(.ID_WIDTH(ID_WIDTH)) u_index (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (idx_clr),
        .adv_i  (idx_adv),
        .idx_o  (idx),
        .last_o (last_bit)
    );

    srch_id_select #(.ID_WIDTH(ID_WIDTH), .ID_VALUE(ID_VALUE)) u_select (
        .idx_i (idx),
        .bit_o (cur_bit)
    );

    srch_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .rd_i      (rd_slot_i),
        .wr_i      (wr_slot_i),
        .match_i   (wr_bit_i == cur_bit),
        .last_i    (last_bit),
        .state_o   (state),
        .idx_clr_o (idx_clr),
        .idx_adv_o (idx_adv)
    );

    always_comb begin
        line_o = 1'b1;
        unique case (state)
            S_SEND_TRUE: line_o = cur_bit;
            S_SEND_COMP: line_o = ~cur_bit;
            S_STREAM:    line_o = pio_i;
            default:     line_o = 1'b1;
        endcase
    end

    assign selected_o = is_active(state);
    assign done_o     = (state == S_STREAM);

    // R6
    release_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !selected_o |-> line_o);

    // R5
    mismatch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AWAIT_WR && wr_slot_i && !rd_slot_i && !start_i && (wr_bit_i != cur_bit))
        |=> !selected_o);

    // R7
    final_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_AWAIT_WR && wr_slot_i && !rd_slot_i && !start_i &&
         (wr_bit_i == cur_bit) && last_bit) |=> done_o);

    // R12
    slot_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_slot_i && wr_slot_i && !start_i && state != S_IDLE) |=> !selected_o);

endmodule

// File: tb/srch_responder_tb.sv
`timescale 1ns/1ps
module srch_responder_tb;

    localparam int         W  = 8;
    localparam logic [7:0] ID = 8'b1011_0010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, rd = 1'b0, wr = 1'b0, wbit = 1'b0, pio = 1'b0;
    logic line, sel, done;
    int   checks = 0;
    int   errors = 0;

    always #2.5 clk = ~clk;

    srch_responder #(.ID_WIDTH(W), .ID_VALUE(ID)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .rd_slot_i(rd),
        .wr_slot_i(wr), .wr_bit_i(wbit), .pio_i(pio),
        .line_o(line), .selected_o(sel), .done_o(done)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic rd_slot(output logic b);
        @(negedge clk);
        b  = line;
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wr_slot(input logic b);
        @(negedge clk);
        wr   = 1'b1;
        wbit = b;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic match_bits(input int n);
        logic b;
        for (int i = 0; i < n; i++) begin
            rd_slot(b); chk(b, ID[i], "R3 true bit");
            rd_slot(b); chk(b, ~ID[i], "R3 complement bit");
            wr_slot(ID[i]);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(line, 1'b1, "R1 line released");
        chk(sel, 1'b0, "R1 not selected");
        chk(done, 1'b0, "R1 not done");
    endtask

    task automatic t_full_pass();
        logic b;
        pulse_start();
        chk(sel, 1'b1, "R2 selected after start");
        for (int i = 0; i < W; i++) begin
            rd_slot(b); chk(b, ID[i], (i == 0) ? "R2 lsb first" : "R4 next bit");
            rd_slot(b); chk(b, ~ID[i], "R3 complement");
            wr_slot(ID[i]);
            @(negedge clk);
            chk(sel, 1'b1, "R4 stays selected");
            if (i < W - 1) chk(done, 1'b0, "R7 done not early");
        end
        chk(done, 1'b1, "R7 done after last bit");
        pio = 1'b0; rd_slot(b); chk(b, 1'b0, "R7 pio low");
        pio = 1'b1; rd_slot(b); chk(b, 1'b1, "R7 pio high");
        pio = 1'b0; rd_slot(b); chk(b, 1'b0, "R7 pio low again");
    endtask

    task automatic t_mismatch();
        logic b;
        pulse_start();
        match_bits(3);
        rd_slot(b); chk(b, ID[3], "R3 bit3");
        rd_slot(b); chk(b, ~ID[3], "R3 bit3 comp");
        wr_slot(~ID[3]);
        @(negedge clk);
        chk(sel, 1'b0, "R5 dropped on mismatch");
        for (int i = 0; i < 6; i++) begin
            rd_slot(b); chk(b, 1'b1, "R6 released while inactive");
        end
        wr_slot(ID[4]);
        @(negedge clk);
        chk(sel, 1'b0, "R5 stays dropped");
        chk(done, 1'b0, "R5 never done");
    endtask

    task automatic t_restart_mid();
        logic b;
        pulse_start();
        match_bits(2);
        rd_slot(b); chk(b, ID[2], "R3 bit2");
        pulse_start();
        chk(sel, 1'b1, "R10 selected after restart");
        rd_slot(b); chk(b, ID[0], "R10 restart at bit 0");
        rd_slot(b); chk(b, ~ID[0], "R10 restart comp");
    endtask

    task automatic t_write_early();
        logic b;
        pulse_start();
        wr_slot(ID[0]);
        @(negedge clk);
        chk(sel, 1'b0, "R8 write in place of read");
        rd_slot(b); chk(b, 1'b1, "R8 line released");
        pulse_start();
        rd_slot(b);
        wr_slot(ID[0]);
        @(negedge clk);
        chk(sel, 1'b0, "R8 write in place of complement read");
    endtask

    task automatic t_read_late();
        logic b;
        pulse_start();
        rd_slot(b);
        rd_slot(b);
        rd_slot(b);
        chk(b, 1'b1, "R9 await-write line released");
        @(negedge clk);
        chk(sel, 1'b0, "R9 read in place of write");
    endtask

    task automatic t_stream_write();
        logic b;
        pulse_start();
        match_bits(W);
        @(negedge clk);
        chk(done, 1'b1, "R11 reached stream");
        wr_slot(1'b1);
        @(negedge clk);
        chk(sel, 1'b0, "R11 dropped by write");
        chk(done, 1'b0, "R11 done cleared");
        pio = 1'b0;
        rd_slot(b); chk(b, 1'b1, "R11 pio ignored after drop");
    endtask

    task automatic t_clash();
        pulse_start();
        @(negedge clk);
        rd = 1'b1; wr = 1'b1; wbit = ID[0];
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
        @(negedge clk);
        chk(sel, 1'b0, "R12 simultaneous slots");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_pass();
        t_mismatch();
        t_restart_mid();
        t_write_early();
        t_read_late();
        t_stream_write();
        t_clash();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule